// File: doc/BRIEF.md
# Multi-channel ADC threshold monitor

This block watches a stream of ADC conversion results against per-channel limits. Each of its eight monitor channels names one ADC input by a tag byte and holds a 16-bit low limit and a 16-bit high limit. When a sample arrives whose tag matches a measuring channel, a code under the low limit or over the high limit sets a sticky status bit for that channel and direction. A single interrupt line is the OR of all status bits that are qualified by their channel's measurement enable and by that direction's interrupt enable.

The block also paces the external ADC. Each measuring channel runs an interval counter on a prescaled tick. The counter's period comes from one of three shared timer fields, picked per channel. When the counter expires, the channel has a conversion request pending. Pending requests go out one per cycle, round-robin in ascending channel order, each carrying the channel's ADC tag. Software sees everything through a byte-wide register port: a window of eight bytes per channel, two status bytes with write-one-to-clear, shared parameter bytes, a global enable and a start strobe.

Top module: `thr_monitor`

## Requirements
- R1: After reset, every register reads 0, except offset 0x0f, which returns the channel count (8). irq and conv_req are low.
- R2: Channel n owns offsets 0x60+8n to 0x67+8n, laid out as follows. Byte +0 is the ADC tag. Bytes +1/+2 are the low limit, low byte first. Bytes +3/+4 are the high limit, low byte first. Byte +5 bits 1:0 are the interval select. Byte +6 bits 5:0 are the control field. Byte +7 holds bit 7 measure-enable, bit 1 high-interrupt-enable and bit 0 low-interrupt-enable. Unimplemented bits read 0.
- R3: Offsets 0x42 to 0x45 are the shared parameter bytes and read back as written. Offset 0x45 holds timer 2 in bits 7:4 and timer 3 in bits 3:0. Offset 0x0f is read-only, and writes to it are ignored.
- R4: Monitoring is active only when 0x46 bit 7 is set and a write with bit 7 set to 0x47 has happened since; 0x47 bit 7 reads back this started state. A start write while 0x46 bit 7 is clear has no effect. Clearing 0x46 bit 7 stops monitoring, and a new start is then needed.
- R5: While active, a measuring channel issues a conversion request every (T+1)·PRESCALE clock cycles. T is taken from a source picked by the channel's interval select: 0x44 for select 0, 0x45[7:4] for select 1, 0x45[3:0] for select 2 or 3.
- R6: conv_req is a one-cycle pulse per request, and conv_tag carries the requesting channel's ADC tag. Requests that are pending in the same cycle go out on consecutive cycles in ascending channel order, starting after the last channel served.
- R7: A valid sample while active sets status bits only for channels whose tag matches and whose measure-enable is set. A code strictly below the low limit sets bit n of 0x0a. A code strictly above the high limit sets bit n of 0x0b. A code equal to a limit sets nothing.
- R8: Status bits hold until software writes 1 to that bit at 0x0a or 0x0b. Writing 0 has no effect. A set and a clear in the same cycle leave the bit set.
- R9: irq is high exactly when some channel has measure-enable set and either its low status and low-interrupt-enable are both set, or its high status and high-interrupt-enable are both set. A status bit that does not qualify stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| smp_valid | input | 1 | Sample present this cycle |
| smp_tag | input | 8 | ADC tag of the sample |
| smp_code | input | 16 | Conversion code |
| conv_req | output | 1 | Conversion request pulse |
| conv_tag | output | 8 | ADC tag for the request |
| irq | output | 1 | Combined interrupt |

## Verification
Four properties are checked on every cycle by assertions. A request never leaves while monitoring is inactive or while nothing is pending. A status bit only rises after a sample cycle. Status bits stay put while neither a sample nor a write is present. A write-one-to-clear always removes the written bits unless a sample arrives in the same cycle. The bench's directed scenarios are what show the remaining behaviour: the exact request periods for each timer source, the ascending order of simultaneous requests, the strict inequality at both limits, the priority of set over clear, and the qualification of the interrupt.

// File: rtl/thr_monitor.sv
module thr_monitor #(
  parameter int NCH      = 8,
  parameter int PRESCALE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        smp_valid,
  input  logic [7:0]  smp_tag,
  input  logic [15:0] smp_code,
  output logic        conv_req,
  output logic [7:0]  conv_tag,
  output logic        irq
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int WIN_BASE = 'h60;
  localparam int WIN_LAST = WIN_BASE + 8 * NCH - 1;

  logic [7:0]  sel_q [NCH];
  logic [15:0] lo_q  [NCH];
  logic [15:0] hi_q  [NCH];
  logic [1:0]  ivl_q [NCH];
  logic [5:0]  ctl_q [NCH];
  logic [7:0]  cnt_q [NCH];
  logic [7:0]  lim   [NCH];
  logic [NCH-1:0] meas_q, hie_q, lie_q, st_lo, st_hi, pend_q;
  logic [NCH-1:0] set_lo, set_hi, clr_lo, clr_hi, wrap;
  logic [7:0] dec_q, avg_q, t1_q, t23_q;
  logic gen_q, run_q;
  logic [PW-1:0] pcnt_q;
  logic [CW-1:0] ptr_q, gnt;
  logic gnt_ok;

  wire active = gen_q & run_q;
  wire tick   = active && (pcnt_q == PW'(PRESCALE - 1));
  wire win_hit = int'(reg_addr) >= WIN_BASE && int'(reg_addr) <= WIN_LAST;
  wire [7:0] win_off = reg_addr - 8'h60;
  wire [CW-1:0] win_ch = win_off[CW+2:3];
  wire [2:0] wo = win_off[2:0];

  assign clr_lo = (reg_we && reg_addr == 8'h0a) ? reg_wdata[NCH-1:0] : '0;
  assign clr_hi = (reg_we && reg_addr == 8'h0b) ? reg_wdata[NCH-1:0] : '0;
  assign irq = |(meas_q & ((st_lo & lie_q) | (st_hi & hie_q)));

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      set_lo[c] = smp_valid && active && meas_q[c] && sel_q[c] == smp_tag && smp_code < lo_q[c];
      set_hi[c] = smp_valid && active && meas_q[c] && sel_q[c] == smp_tag && smp_code > hi_q[c];
      case (ivl_q[c])
        2'd0:    lim[c] = t1_q;
        2'd1:    lim[c] = {4'h0, t23_q[7:4]};
        default: lim[c] = {4'h0, t23_q[3:0]};
      endcase
      wrap[c] = tick && meas_q[c] && cnt_q[c] >= lim[c];
    end
  end

  always_comb begin
    int idx;
    gnt_ok = 1'b0;
    gnt = '0;
    for (int i = 0; i < NCH; i++) begin
      idx = (int'(ptr_q) + i) % NCH;
      if (!gnt_ok && pend_q[idx]) begin
        gnt_ok = 1'b1;
        gnt = CW'(idx);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (win_hit) begin
      case (wo)
        3'd0: reg_rdata = sel_q[win_ch];
        3'd1: reg_rdata = lo_q[win_ch][7:0];
        3'd2: reg_rdata = lo_q[win_ch][15:8];
        3'd3: reg_rdata = hi_q[win_ch][7:0];
        3'd4: reg_rdata = hi_q[win_ch][15:8];
        3'd5: reg_rdata = {6'h0, ivl_q[win_ch]};
        3'd6: reg_rdata = {2'h0, ctl_q[win_ch]};
        default: reg_rdata = {meas_q[win_ch], 5'h0, hie_q[win_ch], lie_q[win_ch]};
      endcase
    end else begin
      case (reg_addr)
        8'h0a: reg_rdata = 8'(st_lo);
        8'h0b: reg_rdata = 8'(st_hi);
        8'h0f: reg_rdata = 8'(NCH);
        8'h42: reg_rdata = dec_q;
        8'h43: reg_rdata = avg_q;
        8'h44: reg_rdata = t1_q;
        8'h45: reg_rdata = t23_q;
        8'h46: reg_rdata = {gen_q, 7'h0};
        8'h47: reg_rdata = {run_q, 7'h0};
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        sel_q[c] <= '0; lo_q[c] <= '0; hi_q[c] <= '0;
        ivl_q[c] <= '0; ctl_q[c] <= '0; cnt_q[c] <= '0;
      end
      {meas_q, hie_q, lie_q, st_lo, st_hi, pend_q} <= '0;
      {dec_q, avg_q, t1_q, t23_q} <= '0;
      gen_q <= 1'b0; run_q <= 1'b0;
      pcnt_q <= '0; ptr_q <= '0;
      conv_req <= 1'b0; conv_tag <= '0;
    end else begin
      if (reg_we && win_hit) begin
        case (wo)
          3'd0: sel_q[win_ch] <= reg_wdata;
          3'd1: lo_q[win_ch][7:0] <= reg_wdata;
          3'd2: lo_q[win_ch][15:8] <= reg_wdata;
          3'd3: hi_q[win_ch][7:0] <= reg_wdata;
          3'd4: hi_q[win_ch][15:8] <= reg_wdata;
          3'd5: ivl_q[win_ch] <= reg_wdata[1:0];
          3'd6: ctl_q[win_ch] <= reg_wdata[5:0];
          default: begin
            meas_q[win_ch] <= reg_wdata[7];
            hie_q[win_ch] <= reg_wdata[1];
            lie_q[win_ch] <= reg_wdata[0];
          end
        endcase
      end else if (reg_we) begin
        case (reg_addr)
          8'h42: dec_q <= reg_wdata;
          8'h43: avg_q <= reg_wdata;
          8'h44: t1_q <= reg_wdata;
          8'h45: t23_q <= reg_wdata;
          8'h46: gen_q <= reg_wdata[7];
          default: ;
        endcase
      end
      if (!gen_q) run_q <= 1'b0;
      else if (reg_we && reg_addr == 8'h47 && reg_wdata[7]) run_q <= 1'b1;

      st_lo <= (st_lo & ~clr_lo) | set_lo;
      st_hi <= (st_hi & ~clr_hi) | set_hi;

      if (!active || tick) pcnt_q <= '0;
      else pcnt_q <= pcnt_q + 1'b1;

      for (int c = 0; c < NCH; c++) begin
        if (!(active && meas_q[c])) begin
          cnt_q[c] <= '0;
          pend_q[c] <= 1'b0;
        end else begin
          if (wrap[c]) cnt_q[c] <= '0;
          else if (tick) cnt_q[c] <= cnt_q[c] + 1'b1;
          pend_q[c] <= wrap[c] | (pend_q[c] & ~(gnt_ok && gnt == CW'(c)));
        end
      end

      conv_req <= gnt_ok && active;
      if (gnt_ok) conv_tag <= sel_q[gnt];
      if (!active) ptr_q <= '0;
      else if (gnt_ok) ptr_q <= gnt + 1'b1;
    end
  end

  p_req_only_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> $past(active));

  p_req_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> $past(|pend_q));

  p_status_from_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|((st_lo & ~$past(st_lo)) | (st_hi & ~$past(st_hi)))) |-> $past(smp_valid));

  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!smp_valid && !reg_we) |-> ($stable(st_lo) && $stable(st_hi)));

  p_w1c_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == 8'h0a && !smp_valid) |-> ((st_lo & $past(reg_wdata[NCH-1:0])) == '0));
endmodule

// File: tb/tb_thr_monitor.sv
module tb_thr_monitor;
  localparam int NCH = 8;
  localparam int PRESCALE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, smp_valid = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, smp_tag = '0;
  logic [15:0] smp_code = '0;
  logic [7:0] reg_rdata, conv_tag;
  logic conv_req, irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  thr_monitor #(.NCH(NCH), .PRESCALE(PRESCALE)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_tag(smp_tag), .smp_code(smp_code), .conv_req(conv_req),
    .conv_tag(conv_tag), .irq(irq));

  task automatic chk(input string r, input int a, input int e);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); reg_addr = a; #1 v = int'(reg_rdata);
  endtask

  task automatic smp(input logic [7:0] t, input logic [15:0] c);
    @(negedge clk); smp_valid = 1'b1; smp_tag = t; smp_code = c;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!conv_req && n < 2000);
  endtask

  task automatic clear_status();
    wr(8'h0a, 8'hff); wr(8'h0b, 8'hff);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, n;
    int mask [8] = '{8'hff, 8'hff, 8'hff, 8'hff, 8'hff, 8'h03, 8'h3f, 8'h83};
    int ivsel [6] = '{0, 0, 0, 1, 2, 3};
    int t1v   [6] = '{0, 2, 5, 0, 0, 0};
    int t23v  [6] = '{0, 0, 0, 'h30, 'h31, 'h07};
    int per   [6] = '{1, 3, 6, 4, 2, 8};
    int codes [8] = '{0, 'h0fff, 'h1000, 'h1001, 'h1fff, 'h2000, 'h2001, 'hffff};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h0a, v); chk("R1 low status", v, 0);
    rd(8'h0b, v); chk("R1 high status", v, 0);
    rd(8'h46, v); chk("R1 global enable", v, 0);
    rd(8'h67, v); chk("R1 channel enable byte", v, 0);
    rd(8'h0f, v); chk("R1 channel count", v, NCH);
    chk("R1 irq", int'(irq), 0);
    chk("R1 conv_req", int'(conv_req), 0);

    // R2 channel window sweep
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 8; o++)
        wr(8'(8'h60 + 8 * c + o), 8'((c * 37 + o * 11 + 5) & 8'hff));
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 8; o++) begin
        rd(8'(8'h60 + 8 * c + o), v);
        chk("R2 window readback", v, ((c * 37 + o * 11 + 5) & 8'hff) & mask[o]);
      end
    for (int a = 8'h60; a < 8'h60 + 8 * NCH; a++) wr(8'(a), 8'h00);

    // R3 shared parameters and read-only count
    for (int a = 8'h42; a <= 8'h45; a++) wr(8'(a), 8'(a * 3 + 1));
    for (int a = 8'h42; a <= 8'h45; a++) begin
      rd(8'(a), v); chk("R3 parameter readback", v, (a * 3 + 1) & 8'hff);
    end
    wr(8'h0f, 8'h55);
    rd(8'h0f, v); chk("R3 count read-only", v, NCH);

    // R4 start gating
    wr(8'h60, 8'h20); wr(8'h67, 8'h80); wr(8'h44, 8'h00);
    wr(8'h47, 8'h80);
    wr(8'h46, 8'h80);
    rd(8'h47, v); chk("R4 start ignored while disabled", v, 0);
    n = 0;
    repeat (60) begin @(negedge clk); if (conv_req) n++; end
    chk("R4 no request before start", n, 0);
    wr(8'h47, 8'h80);
    rd(8'h47, v); chk("R4 started flag", v, 8'h80);
    wait_req(n); chk("R4 request after start", int'(conv_req), 1);
    chk("R6 request tag", int'(conv_tag), 8'h20);
    wr(8'h46, 8'h00);
    @(negedge clk);
    n = 0;
    repeat (60) begin @(negedge clk); if (conv_req) n++; end
    chk("R4 stop after disable", n, 0);
    wr(8'h46, 8'h80);
    rd(8'h47, v); chk("R4 restart needed", v, 0);

    // R5 interval periods
    for (int k = 0; k < 6; k++) begin
      wr(8'h46, 8'h00);
      wr(8'h44, 8'(t1v[k])); wr(8'h45, 8'(t23v[k])); wr(8'h65, 8'(ivsel[k]));
      wr(8'h46, 8'h80); wr(8'h47, 8'h80);
      wait_req(n);
      wait_req(n);
      chk("R5 request period", n, per[k] * PRESCALE);
    end

    // R6 ascending round-robin
    wr(8'h46, 8'h00); wr(8'h67, 8'h00); wr(8'h65, 8'h00); wr(8'h44, 8'h01);
    wr(8'h68, 8'h31); wr(8'h6f, 8'h80);
    wr(8'h78, 8'h33); wr(8'h7f, 8'h80);
    wr(8'h90, 8'h36); wr(8'h97, 8'h80);
    wr(8'h46, 8'h80); wr(8'h47, 8'h80);
    for (int r = 0; r < 2; r++) begin
      wait_req(n); chk("R6 first tag", int'(conv_tag), 8'h31);
      @(negedge clk); chk("R6 second pulse", int'(conv_req), 1);
      chk("R6 second tag", int'(conv_tag), 8'h33);
      @(negedge clk); chk("R6 third pulse", int'(conv_req), 1);
      chk("R6 third tag", int'(conv_tag), 8'h36);
      @(negedge clk); chk("R6 burst ends", int'(conv_req), 0);
    end
    wr(8'h6f, 8'h00); wr(8'h7f, 8'h00); wr(8'h97, 8'h00);

    // R7 comparison sweep on channel 2
    wr(8'h70, 8'h42);
    wr(8'h71, 8'h00); wr(8'h72, 8'h10);
    wr(8'h73, 8'h00); wr(8'h74, 8'h20);
    wr(8'h77, 8'h80);
    for (int k = 0; k < 8; k++) begin
      clear_status();
      smp(8'h42, 16'(codes[k]));
      rd(8'h0a, v); chk("R7 low status", v, (codes[k] < 'h1000) ? 8'h04 : 0);
      rd(8'h0b, v); chk("R7 high status", v, (codes[k] > 'h2000) ? 8'h04 : 0);
    end
    clear_status();
    smp(8'h43, 16'h0000);
    rd(8'h0a, v); chk("R7 tag mismatch ignored", v, 0);
    wr(8'h77, 8'h00);
    smp(8'h42, 16'h0000);
    rd(8'h0a, v); chk("R7 measure disabled ignored", v, 0);
    wr(8'h77, 8'h80);

    // R8 sticky and write-one-to-clear
    smp(8'h42, 16'h0fff);
    wr(8'h0a, 8'hfb);
    rd(8'h0a, v); chk("R8 other bits cleared only", v, 8'h04);
    wr(8'h0a, 8'h00);
    rd(8'h0a, v); chk("R8 zero write kept", v, 8'h04);
    wr(8'h0a, 8'h04);
    rd(8'h0a, v); chk("R8 one write clears", v, 0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h0a; reg_wdata = 8'h04;
    smp_valid = 1'b1; smp_tag = 8'h42; smp_code = 16'h0fff;
    @(negedge clk); reg_we = 1'b0; smp_valid = 1'b0;
    rd(8'h0a, v); chk("R8 set wins over clear", v, 8'h04);

    // R9 interrupt qualification
    chk("R9 no direction enabled", int'(irq), 0);
    wr(8'h77, 8'h81); chk("R9 low enabled", int'(irq), 1);
    wr(8'h77, 8'h82); chk("R9 only high enabled", int'(irq), 0);
    wr(8'h77, 8'h01); chk("R9 measure off", int'(irq), 0);
    rd(8'h0a, v); chk("R9 status still readable", v, 8'h04);
    wr(8'h77, 8'h81); chk("R9 requalified", int'(irq), 1);
    wr(8'h0a, 8'h04); chk("R9 cleared", int'(irq), 0);
    wr(8'h77, 8'h82);
    smp(8'h42, 16'h3000);
    chk("R9 high direction", int'(irq), 1);
    wr(8'h0b, 8'h04); chk("R9 high cleared", int'(irq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule